// File: doc/BRIEF.md
# Hibernate Entry and Wake Sequencer

This always-powered controller decides when the system drops into hibernation and when it comes back. Software writes a control word that holds a one-shot hibernate request, two wake-path enables (wake pin and real-time-clock match) and a 2-bit battery threshold select. A request is accepted only if at least one of those two paths is enabled and the chosen battery comparator output is high. An accepted request starts a short entry phase of `ENTRY_CYC` cycles. At its end the block raises an active-high regulator-off output that removes main power. The block itself keeps running from the backup supply.

While entering or hibernating, any enabled wake source ends the sequence. The regulator-off output drops so main power returns, and the sources that fired are latched into a status vector. A wake during the entry phase aborts the entry before power is ever removed. A rejected request sets a sticky flag in the same vector. Software clears status bits by writing ones to them.

Top module: `hib_seq`

## Requirements
- R1: A control write (address 0) with bit 0 set, issued while idle, with bit 1 (pin-wake enable) or bit 2 (clock-wake enable) set and `bat_ok[wr_data[4:3]]` high, raises `reg_off` exactly `ENTRY_CYC` rising edges after the write edge.
- R2: A request with both bits 1 and 2 of the written word clear is dropped: `reg_off` stays low and status bit 12 (reject) sets.
- R3: A request whose selected battery comparator bit `bat_ok[wr_data[4:3]]` is low is dropped the same way, setting status bit 12.
- R4: After reset `reg_off` is low and `wake_stat` is zero. `reg_off` is high only while hibernating.
- R5: An enabled wake event while hibernating drops `reg_off`. Level sources (external reset, tamper, oscillator fail, clock match) act on the edge where they are high. Wake pin and GPIO inputs act on a rising edge through a two-flop synchronizer, on the third clock edge counting the first edge that sees them high.
- R6: A source whose enable is clear has no effect. Enables: wake pin = control bit 1; clock match = control bit 2; external reset, GPIO 4..7, tamper 0..3 and oscillator fail = bits 1..10 of the source-enable word (address 1).
- R7: An enabled wake event during the entry phase aborts it. The block returns to idle with `reg_off` never raised.
- R8: Status bit positions: 0 wake pin, 1 external reset, 2..5 GPIO 4..7, 6..9 tamper 0..3, 10 oscillator fail, 11 clock match, 12 reject. A wake sets the bits of all enabled sources firing on that edge. A write to address 2 clears the bits written as one. Events while idle set nothing.
- R9: A request written while entering or hibernating is ignored and sets no reject flag. The request bit is not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Backup-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 control, 1 source enables, 2 status clear |
| wr_data | input | DW | Write data |
| bat_ok | input | 4 | Battery comparator outputs, one per threshold |
| wake_pin | input | 1 | Asynchronous external wake pin |
| ext_rst | input | 1 | External reset event (synchronous level) |
| gpio_wake | input | 4 | Asynchronous GPIO K4..K7 wake inputs |
| tamper | input | 4 | Tamper events (synchronous level) |
| osc_fail | input | 1 | Tamper oscillator failure flag |
| rtc_match | input | 1 | Real-time clock match event |
| reg_off | output | 1 | High removes main power |
| wake_stat | output | 13 | Wake source and reject status |

## Verification
A corrupted sequencer state shows at `reg_off` within one edge: power is removed early, never removed, or never restored. A wrong entry counter moves the rising edge of `reg_off` off its exact cycle. A lost synchronizer stage moves the wake release by one edge. A wrong enable mask or status latch shows in `wake_stat` on the edge after the offending event. Every edge is compared with a behavioural model, so each of these is caught on the cycle it first appears.

// File: rtl/hib_seq_pkg.sv
package hib_seq_pkg;
  localparam int NSRC    = 12;
  localparam int SW      = NSRC + 1;
  localparam int REJ_BIT = NSRC;
  localparam int NSYNC   = 5;

  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_ENTER = 2'd1, ST_HIB = 2'd2} hib_st_t;

  // request qualification: a wake path must exist and the chosen battery level be good
  function automatic logic entry_allowed(input logic pin_en, input logic clk_en,
                                         input logic [3:0] lvl_ok, input logic [1:0] sel);
    return (pin_en | clk_en) & lvl_ok[sel];
  endfunction

  function automatic logic [NSRC-1:0] armed_events(input logic [NSRC-1:0] ev,
                                                   input logic [NSRC-1:0] en);
    return ev & en;
  endfunction
endpackage

// File: rtl/hib_wake_sync.sv
module hib_wake_sync #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] rise
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1, s2, s3;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= 1'b0;
        s2 <= 1'b0;
        s3 <= 1'b0;
      end else begin
        s1 <= din[i];
        s2 <= s1;
        s3 <= s2;
      end
    end
    assign rise[i] = s2 & ~s3;

    AST_RISE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      rise[i] |=> !rise[i]); // R5
  end
endmodule

// File: rtl/hib_wake_arb.sv
module hib_wake_arb
  import hib_seq_pkg::*;
(
  input  logic            pin_rise,
  input  logic            ext_rst,
  input  logic [3:0]      gpio_rise,
  input  logic [3:0]      tamper,
  input  logic            osc_fail,
  input  logic            rtc_match,
  input  logic            pin_wen,
  input  logic            rtc_wen,
  input  logic [NSRC-3:0] mid_en,
  output logic [NSRC-1:0] src_en,
  output logic [NSRC-1:0] hit,
  output logic            any_hit
);
  logic [NSRC-1:0] ev;
  assign ev      = {rtc_match, osc_fail, tamper, gpio_rise, ext_rst, pin_rise};
  assign src_en  = {rtc_wen, mid_en, pin_wen};
  assign hit     = armed_events(ev, src_en);
  assign any_hit = |hit;
endmodule

// File: rtl/hib_seq.sv
module hib_seq
  import hib_seq_pkg::*;
#(
  parameter int ENTRY_CYC = 4,
  parameter int DW        = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [3:0]    bat_ok,
  input  logic          wake_pin,
  input  logic          ext_rst,
  input  logic [3:0]    gpio_wake,
  input  logic [3:0]    tamper,
  input  logic          osc_fail,
  input  logic          rtc_match,
  output logic          reg_off,
  output logic [SW-1:0] wake_stat
);
  localparam int CW = $clog2(ENTRY_CYC + 1);

  hib_st_t         st;
  logic [CW-1:0]   cnt;
  logic            pin_wen_q, rtc_wen_q;
  logic [NSRC-3:0] mid_en_q;
  logic [NSYNC-1:0] rise;
  logic [NSRC-1:0] src_en, hit;
  logic            any_hit;

  hib_wake_sync #(.W(NSYNC)) u_sync (
    .clk(clk), .rst_n(rst_n), .din({gpio_wake, wake_pin}), .rise(rise));

  hib_wake_arb u_arb (
    .pin_rise(rise[0]), .ext_rst(ext_rst), .gpio_rise(rise[4:1]), .tamper(tamper),
    .osc_fail(osc_fail), .rtc_match(rtc_match), .pin_wen(pin_wen_q),
    .rtc_wen(rtc_wen_q), .mid_en(mid_en_q), .src_en(src_en), .hit(hit),
    .any_hit(any_hit));

  // named internal events
  logic ctrl_wr, req_bit, req_ok, req_accept, req_reject, wake_take, entry_done;
  logic [SW-1:0] w1c;
  assign ctrl_wr    = wr_en && (wr_addr == 2'd0);
  assign req_bit    = ctrl_wr && wr_data[0];
  assign req_ok     = entry_allowed(wr_data[1], wr_data[2], bat_ok, wr_data[4:3]);
  assign req_accept = req_bit && (st == ST_IDLE) && req_ok;
  assign req_reject = req_bit && (st == ST_IDLE) && !req_ok;
  assign wake_take  = any_hit && (st != ST_IDLE);
  assign entry_done = (st == ST_ENTER) && !any_hit && (cnt == CW'(ENTRY_CYC - 1));
  assign w1c        = (wr_en && (wr_addr == 2'd2)) ? wr_data[SW-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_wen_q <= 1'b0;
      rtc_wen_q <= 1'b0;
      mid_en_q  <= '0;
    end else begin
      if (ctrl_wr) begin
        pin_wen_q <= wr_data[1];
        rtc_wen_q <= wr_data[2];
      end
      if (wr_en && (wr_addr == 2'd1)) mid_en_q <= wr_data[NSRC-2:1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      cnt     <= '0;
      reg_off <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: if (req_accept) begin
          st  <= ST_ENTER;
          cnt <= '0;
        end
        ST_ENTER: begin
          if (wake_take) st <= ST_IDLE;
          else if (entry_done) begin
            st      <= ST_HIB;
            reg_off <= 1'b1;
          end else cnt <= cnt + 1'b1;
        end
        ST_HIB: if (wake_take) begin
          st      <= ST_IDLE;
          reg_off <= 1'b0;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wake_stat <= '0;
    else wake_stat <= (wake_stat & ~w1c)
                    | (wake_take ? {1'b0, hit} : '0)
                    | (req_reject ? SW'(1) << REJ_BIT : '0);
  end

  AST_ENTRY_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reg_off) |-> $past(st) == ST_ENTER); // R1
  AST_REJECT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    req_reject |=> (st == ST_IDLE) && wake_stat[REJ_BIT] && !reg_off); // R2
  AST_WAKE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_HIB) && wake_take |=> !reg_off); // R5
  AST_ABORT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ENTER) && wake_take |=> (st == ST_IDLE) && !reg_off); // R7
  AST_STAT_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((wake_stat[NSRC-1:0] & ~$past(wake_stat[NSRC-1:0]) & ~$past(src_en)) == '0)); // R6
  AST_BUSY_NO_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    req_bit && (st != ST_IDLE) && !wake_stat[REJ_BIT] |=> !wake_stat[REJ_BIT]); // R9
endmodule

// File: tb/sim_hib_seq.sv
`timescale 1ns/1ps
module sim_hib_seq;
  localparam int ENTRY_CYC = 4;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0;
  logic [1:0] wr_addr = 0;
  logic [15:0] wr_data = 0;
  logic [3:0] bat_ok = 4'hF;
  logic wake_pin = 0, ext_rst = 0, osc_fail = 0, rtc_match = 0;
  logic [3:0] gpio_wake = 0, tamper = 0;
  logic reg_off;
  logic [12:0] wake_stat;
  int checks = 0, errors = 0, cyc = 0;

  always #5 clk = ~clk;

  hib_seq #(.ENTRY_CYC(ENTRY_CYC), .DW(16)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .bat_ok(bat_ok), .wake_pin(wake_pin), .ext_rst(ext_rst), .gpio_wake(gpio_wake),
    .tamper(tamper), .osc_fail(osc_fail), .rtc_match(rtc_match),
    .reg_off(reg_off), .wake_stat(wake_stat));

  // behavioural reference: 0 idle, 1 entering, 2 off
  int m_st, m_cnt;
  logic m_off, m_pin, m_rtc;
  logic [9:0] m_mid;
  logic [12:0] m_stat, nstat;
  logic [4:0] h1, h2, h3, edges;
  logic [11:0] ev, en, hit;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_off = 0; m_pin = 0; m_rtc = 0; m_mid = 0; m_stat = 0;
      h1 = 0; h2 = 0; h3 = 0;
    end else begin
      edges = h2 & ~h3;
      h3 = h2; h2 = h1; h1 = {gpio_wake, wake_pin};
      ev  = {rtc_match, osc_fail, tamper, edges[4:1], ext_rst, edges[0]};
      en  = {m_rtc, m_mid, m_pin};
      hit = ev & en;
      nstat = m_stat;
      if (wr_en && wr_addr == 2) nstat = nstat & ~wr_data[12:0];
      if (m_st == 0) begin
        if (wr_en && wr_addr == 0 && wr_data[0]) begin
          if ((wr_data[1] || wr_data[2]) && bat_ok[wr_data[4:3]]) begin m_st = 1; m_cnt = 0; end
          else nstat[12] = 1;
        end
      end else if (hit != 0) begin
        nstat = nstat | {1'b0, hit}; m_st = 0; m_off = 0;
      end else if (m_st == 1) begin
        if (m_cnt == ENTRY_CYC - 1) begin m_st = 2; m_off = 1; end
        else m_cnt++;
      end
      if (wr_en && wr_addr == 0) begin m_pin = wr_data[1]; m_rtc = wr_data[2]; end
      if (wr_en && wr_addr == 1) m_mid = wr_data[10:1];
      m_stat = nstat;
    end
  end

  always @(negedge clk) if (rst_n) begin
    checks += 2;
    if (reg_off !== m_off) begin errors++; $display("FAIL R4 model reg_off act=%0b exp=%0b", reg_off, m_off); end
    if (wake_stat !== m_stat) begin errors++; $display("FAIL R8 model wake_stat act=%h exp=%h", wake_stat, m_stat); end
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin errors++; $display("FAIL %s act=%h exp=%h", req, act, exp); end
  endtask
  task automatic tick(input int n); repeat (n) @(negedge clk); endtask
  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0; wr_data = 0;
  endtask
  task automatic enter(input logic [15:0] d);
    wr(0, d);
    tick(ENTRY_CYC - 1); chk("R1 early", 16'(reg_off), 16'h0);
    tick(1);             chk("R1 on time", 16'(reg_off), 16'h1);
  endtask
  task automatic done;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin errors++; $display("FAIL watchdog R4 act=%0d exp=0", cyc); done(); end
  end

  initial begin
    tick(2); rst_n = 1; tick(1);
    chk("R4 reset off", 16'(reg_off), 16'h0);
    chk("R4 reset stat", 16'(wake_stat), 16'h0);
    // R2: no wake path
    wr(0, 16'h0001); tick(2);
    chk("R2 off", 16'(reg_off), 16'h0); chk("R2 flag", 16'(wake_stat), 16'h1000);
    wr(2, 16'h1000); chk("R8 clear", 16'(wake_stat), 16'h0);
    // R3: selected level low
    bat_ok = 4'b1011; wr(0, 16'h0013); tick(2);
    chk("R3 off", 16'(reg_off), 16'h0); chk("R3 flag", 16'(wake_stat), 16'h1000);
    wr(2, 16'h1000);
    // R1: selected level good
    enter(16'h000B);
    // R6: disabled tamper
    wr(1, 16'h0000); @(negedge clk); tamper[0] = 1; tick(1); tamper[0] = 0; tick(1);
    chk("R6 off held", 16'(reg_off), 16'h1); chk("R6 stat", 16'(wake_stat), 16'h0);
    // R9: request while off
    wr(0, 16'h000B); tick(ENTRY_CYC + 1);
    chk("R9 off held", 16'(reg_off), 16'h1); chk("R9 no flag", 16'(wake_stat), 16'h0);
    // R5: synchronized pin wake
    @(negedge clk); wake_pin = 1;
    tick(1); chk("R5 pin e1", 16'(reg_off), 16'h1);
    tick(1); chk("R5 pin e2", 16'(reg_off), 16'h1);
    tick(1); chk("R5 pin e3", 16'(reg_off), 16'h0);
    chk("R8 pin bit", 16'(wake_stat), 16'h0001);
    wake_pin = 0; wr(2, 16'h0001);
    // R5: level tamper wake
    wr(1, 16'h0100); enter(16'h000B);
    @(negedge clk); tamper[2] = 1; tick(1); tamper[2] = 0;
    chk("R5 tamper off", 16'(reg_off), 16'h0); chk("R8 tamper bit", 16'(wake_stat), 16'h0100);
    wr(2, 16'h0100);
    // R7: abort during entry
    wr(1, 16'h0002); wr(0, 16'h000B); ext_rst = 1; tick(1); ext_rst = 0;
    tick(ENTRY_CYC + 2);
    chk("R7 never off", 16'(reg_off), 16'h0); chk("R7 stat", 16'(wake_stat), 16'h0002);
    wr(2, 16'h0002);
    // R6: pin disabled, clock-wake only; GPIO K7 wake
    wr(1, 16'h0020); enter(16'h0005);
    @(negedge clk); wake_pin = 1; tick(4); wake_pin = 0;
    chk("R6 pin ignored", 16'(reg_off), 16'h1); tick(2);
    @(negedge clk); gpio_wake[3] = 1; tick(2); chk("R5 gpio e2", 16'(reg_off), 16'h1);
    tick(1); chk("R5 gpio e3", 16'(reg_off), 16'h0);
    chk("R8 gpio bit", 16'(wake_stat), 16'h0020);
    gpio_wake[3] = 0;
    // clock-match wake, partial clear
    enter(16'h0005);
    @(negedge clk); rtc_match = 1; tick(1); rtc_match = 0;
    chk("R5 rtc off", 16'(reg_off), 16'h0); chk("R8 accumulate", 16'(wake_stat), 16'h0820);
    wr(2, 16'h0020); chk("R8 partial clear", 16'(wake_stat), 16'h0800);
    // R8: idle events set nothing
    @(negedge clk); rtc_match = 1; tick(2); rtc_match = 0; tick(1);
    chk("R8 idle ignored", 16'(wake_stat), 16'h0800);
    chk("R4 idle off", 16'(reg_off), 16'h0);
    done();
  end
endmodule